// File: doc/BRIEF.md
# Refresh-Hiding Banked DRAM Controller

This block makes a set of small refreshable storage banks look like a plain single-port SRAM. A requester can issue one read or one write in every cycle and is never stalled. Each request goes to exactly one bank. That bank performs a complete row cycle: it senses the row, writes it back and precharges, all within the request, so no row is ever left open. Every bank that is not addressed in a cycle refreshes one row in that same cycle. A round-robin pointer in each bank picks that row.

A row cache holds one entry per row index and is tagged with a bank number. Its capacity equals one bank. Every row read from a bank is copied into the cache. When a later read hits that copy, the cache returns the data, and the addressed bank is left free to refresh a row of its own. A row that is read over and over therefore cannot starve the other rows of its bank. Writes always go through to the bank. When the written row is also in the cache, the cached copy is updated in the same cycle.

Each row has an age counter that counts the cycles since the row was last accessed or refreshed. A sticky error flag reports that some row has reached the retention limit. The storage is a behavioural model and holds no analog cell detail.

Top module: `drc_top`

## Requirements
- R1: `req_addr` is split as {bank, row}: the upper `$clog2(BANKS)` bits select the bank and the lower `$clog2(ROWS)` bits select the row. Each access moves a whole row of `ROW_W` bits. The defaults are 128 rows of 256 bits per bank.
- R2: A write stores `req_wdata` in exactly one bank row. A later read of the same bank and row returns that data, and writes to other banks or rows do not disturb it.
- R3: In every cycle, each bank that is not addressed refreshes the row at its refresh pointer, clearing that row's age. The pointer then advances by one and wraps from ROWS-1 to 0.
- R4: A read that misses the cache takes its data from the bank and fills the cache entry at that row index, tagged with the bank number. The same row index in a different bank is a miss and returns that bank's own data.
- R5: A read that hits the cache is answered from the cache and does not access the bank. The addressed bank refreshes its pointer row in that cycle instead. Reading one row back to back for many cycles never raises `retention_err`.
- R6: A write to a row that is held in the cache also updates the cached copy, so a read after the write returns the new data.
- R7: `rsp_valid` is high in the cycle after a read is accepted, with `rsp_rdata` holding the row data. It is low after writes and after idle cycles.
- R8: `req_ready` is high at all times, including during reset.
- R9: Each row's age counts the cycles since its last access or refresh. `retention_err` goes high once any age reaches `RETENTION`, stays high, and is cleared only by reset.
- R10: A stream of accesses to different rows of one bank refreshes each row it touches. A write stream that cycles through every row of one bank, and alternating reads that evict each other's cache entries, never raise `retention_err`.
- R11: After reset, `rsp_valid` and `retention_err` are low and every cache entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(BANKS)+$clog2(ROWS) | {bank, row} address |
| req_wdata | input | ROW_W | Write row data |
| req_ready | output | 1 | Always 1; the port never stalls |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | ROW_W | Read row data |
| retention_err | output | 1 | Sticky flag: a row reached the retention limit |

## Verification
The hardest case to reach is the one where the busy bank can only keep its rows alive through the free slot that a cache hit gives it. The bench reads one row for far longer than the retention limit. With the cache working, the other rows of that bank stay young. If hits were sent to the bank, those rows would age past the limit and raise the flag. A separate instance with a very small retention limit is left idle so that the flag is driven high on purpose. That instance shows the flag is sticky and that reset clears it. Alternating reads to the same row index in two banks force eviction after eviction. This exercises the tag compare and the refresh schedule during cycles that are all misses.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int DEF_BANKS     = 4;
    localparam int DEF_ROWS      = 128;
    localparam int DEF_ROW_W     = 256;
    localparam int DEF_RETENTION = 1024;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HIT   = 2'd1,
        ACC_MISS  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic valid, input logic write,
                                           input logic hit);
        if (!valid)      return ACC_IDLE;
        else if (write)  return ACC_WRITE;
        else if (hit)    return ACC_HIT;
        else             return ACC_MISS;
    endfunction

    function automatic int next_index(input int idx, input int limit);
        return (idx == limit - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/drc_bank.sv
module drc_bank
    import drc_pkg::*;
#(
    parameter int ROWS      = DEF_ROWS,
    parameter int ROW_W     = DEF_ROW_W,
    parameter int RETENTION = DEF_RETENTION,
    localparam int ROW_AW   = $clog2(ROWS),
    localparam int AGE_W    = $clog2(RETENTION + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ROW_AW-1:0] acc_row,
    input  logic [ROW_W-1:0]  acc_wdata,
    output logic [ROW_W-1:0]  rd_data,
    output logic              age_over
);

    logic [ROW_W-1:0]  cells [ROWS];
    logic [AGE_W-1:0]  age_q [ROWS];
    logic [ROW_AW-1:0] ptr_q;

    assign rd_data = cells[acc_row];

    always_ff @(posedge clk) begin
        if (acc_en && acc_we) cells[acc_row] <= acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (!acc_en) begin
            ptr_q <= ROW_AW'(next_index(int'(ptr_q), ROWS));
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (rst) begin
                age_q[i] <= '0;
            end else if ((acc_en && acc_row == ROW_AW'(i)) ||
                         (!acc_en && ptr_q == ROW_AW'(i))) begin
                age_q[i] <= '0;
            end else if (age_q[i] != AGE_W'(RETENTION)) begin
                age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        age_over = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            if (age_q[i] >= AGE_W'(RETENTION)) age_over = 1'b1;
        end
    end

    assert_access_renews_row_R10: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (age_q[$past(acc_row)] == '0));

    assert_idle_refresh_R3: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> (age_q[$past(ptr_q)] == '0));

endmodule

// File: rtl/drc_row_cache.sv
module drc_row_cache
    import drc_pkg::*;
#(
    parameter int BANKS   = DEF_BANKS,
    parameter int ROWS    = DEF_ROWS,
    parameter int ROW_W   = DEF_ROW_W,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_AW-1:0] look_row,
    output logic              hit,
    output logic [ROW_W-1:0]  hit_data,
    input  logic              fill_en,
    input  logic              upd_en,
    input  logic [ROW_W-1:0]  new_data
);

    logic              valid_q [ROWS];
    logic [BANK_W-1:0] tag_q   [ROWS];
    logic [ROW_W-1:0]  data_q  [ROWS];

    assign hit      = valid_q[look_row] && (tag_q[look_row] == look_bank);
    assign hit_data = data_q[look_row];

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (fill_en && look_row == ROW_AW'(i)) begin
                valid_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[look_row] <= look_bank;
        if (fill_en || (upd_en && hit)) data_q[look_row] <= new_data;
    end

    assert_fill_tags_entry_R4: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(look_row)] && tag_q[$past(look_row)] == $past(look_bank)));

    assert_write_keeps_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && hit) |=> (data_q[$past(look_row)] == $past(new_data)));

endmodule

// File: rtl/drc_top.sv
module drc_top
    import drc_pkg::*;
#(
    parameter int BANKS     = DEF_BANKS,
    parameter int ROWS      = DEF_ROWS,
    parameter int ROW_W     = DEF_ROW_W,
    parameter int RETENTION = DEF_RETENTION,
    localparam int ROW_AW   = $clog2(ROWS),
    localparam int BANK_W   = $clog2(BANKS),
    localparam int ADDR_W   = BANK_W + ROW_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ROW_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ROW_W-1:0]  rsp_rdata,
    output logic              retention_err
);

    logic [BANK_W-1:0] req_bank;
    logic [ROW_AW-1:0] req_row;
    logic              c_hit;
    logic [ROW_W-1:0]  c_data;
    logic [ROW_W-1:0]  bank_rd [BANKS];
    logic [BANKS-1:0]  bank_en;
    logic [BANKS-1:0]  bank_over;
    acc_kind_e         kind;

    assign req_bank  = req_addr[ADDR_W-1 -: BANK_W];
    assign req_row   = req_addr[ROW_AW-1:0];
    assign req_ready = 1'b1;
    assign kind      = classify(req_valid, req_write, c_hit);

    drc_row_cache #(.BANKS(BANKS), .ROWS(ROWS), .ROW_W(ROW_W)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .look_bank(req_bank),
        .look_row (req_row),
        .hit      (c_hit),
        .hit_data (c_data),
        .fill_en  (kind == ACC_MISS),
        .upd_en   (kind == ACC_WRITE),
        .new_data ((kind == ACC_WRITE) ? req_wdata : bank_rd[req_bank])
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_en[b] = ((kind == ACC_MISS) || (kind == ACC_WRITE)) &&
                            (req_bank == BANK_W'(b));
        drc_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .RETENTION(RETENTION)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .acc_en   (bank_en[b]),
            .acc_we   (req_write),
            .acc_row  (req_row),
            .acc_wdata(req_wdata),
            .rd_data  (bank_rd[b]),
            .age_over (bank_over[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            retention_err <= 1'b0;
        end else begin
            rsp_valid <= (kind == ACC_HIT) || (kind == ACC_MISS);
            if (kind == ACC_HIT)       rsp_rdata <= c_data;
            else if (kind == ACC_MISS) rsp_rdata <= bank_rd[req_bank];
            if (|bank_over) retention_err <= 1'b1;
        end
    end

    assert_single_bank_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_en));

    assert_hit_spares_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && c_hit) |-> (bank_en == '0));

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        retention_err |=> retention_err);

endmodule

// File: tb/tb_drc_top.sv
module tb_drc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int NR  = 8;
    localparam int W   = 16;
    localparam int RET = 48;
    localparam int AW  = $clog2(NB) + $clog2(NR);

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [W-1:0]  req_wdata;
    logic req_ready, rsp_valid, retention_err;
    logic [W-1:0]  rsp_rdata;
    logic t_ready, t_rsp_valid, t_err;
    logic [W-1:0]  t_rdata;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] mdl [NB][NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    drc_top #(.BANKS(NB), .ROWS(NR), .ROW_W(W), .RETENTION(RET)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retention_err(retention_err));

    drc_top #(.BANKS(NB), .ROWS(NR), .ROW_W(W), .RETENTION(4)) dut_tight (
        .clk(clk), .rst(rst), .req_valid(1'b0), .req_write(1'b0),
        .req_addr('0), .req_wdata('0), .req_ready(t_ready),
        .rsp_valid(t_rsp_valid), .rsp_rdata(t_rdata), .retention_err(t_err));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, result visible at following negedge
    task automatic do_write(input int b, input int r, input logic [W-1:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr  = AW'((b << $clog2(NR)) | r); req_wdata = d;
        mdl[b][r] = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 no rsp after write", W'(rsp_valid), W'(0));
    endtask

    task automatic do_read(input int b, input int r, input string tag);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr  = AW'((b << $clog2(NR)) | r);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid R7"}, W'(rsp_valid), W'(1));
        check(tag, rsp_rdata, mdl[b][r]);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        @(negedge clk); @(negedge clk);
        check("R8 ready in reset", W'(req_ready), W'(1));
        rst = 1'b0;
        @(negedge clk);
        check("R11 rsp_valid reset", W'(rsp_valid), W'(0));
        check("R11 err reset", W'(retention_err), W'(0));
    endtask

    task automatic t_fill_all();
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                do_write(b, r, W'(16'h5A00 ^ (b * 37 + r * 11)));
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                do_read(b, r, "R1 R2 readback");
    endtask

    task automatic t_alias();
        // same row index in two banks: each read evicts the other entry (R4)
        for (int k = 0; k < 6; k++) begin
            do_read(1, 3, "R4 alias bank1");
            do_read(2, 3, "R4 alias bank2");
        end
        check("R10 err after eviction stream", W'(retention_err), W'(0));
    endtask

    task automatic t_write_through();
        do_read(0, 5, "R6 prime cache");
        do_write(0, 5, 16'hBEEF);
        do_read(0, 5, "R6 read after write hit");
        do_write(3, 6, 16'h1234);
        do_read(3, 6, "R2 read after write miss");
        do_read(3, 6, "R5 second read hit");
    endtask

    task automatic t_hammer();
        do_read(0, 0, "R5 prime");
        for (int k = 0; k < 4 * RET; k++) begin
            req_valid = 1'b1; req_write = 1'b0; req_addr = '0;
            @(negedge clk);
            if (k % 16 == 0) check("R5 hammer data", rsp_rdata, mdl[0][0]);
        end
        req_valid = 1'b0;
        check("R5 hammer no retention err", W'(retention_err), W'(0));
        check("R8 ready under load", W'(req_ready), W'(1));
    endtask

    task automatic t_write_stream();
        for (int k = 0; k < 30; k++)
            for (int r = 0; r < NR; r++)
                do_write(2, r, W'(k * 97 + r));
        check("R10 write stream no err", W'(retention_err), W'(0));
        do_read(2, 7, "R10 last write");
    endtask

    task automatic t_idle_refresh();
        req_valid = 1'b0;
        for (int k = 0; k < 3 * RET; k++) @(negedge clk);
        check("R3 idle refresh keeps rows", W'(retention_err), W'(0));
        check("R7 idle no rsp", W'(rsp_valid), W'(0));
    endtask

    task automatic t_tight();
        check("R9 tight instance flagged", W'(t_err), W'(1));
        @(negedge clk);
        check("R9 flag sticky", W'(t_err), W'(1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears flag", W'(t_err), W'(0));
        check("R11 err reset main", W'(retention_err), W'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_all();
        t_alias();
        t_write_through();
        t_hammer();
        t_write_stream();
        t_idle_refresh();
        t_tight();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule